// File: doc/BRIEF.md
# Transmit L0s Entry Controller

This block decides when the transmit direction of a switch port may drop into the L0s low-power link state, and when it has to come back out. It watches the port's own traffic indications and the receive-side L0s state of the other ports in its partition. Once every entry condition has held without a break for a fixed qualification window, it issues a one-cycle request to enter transmit L0s.

While the transmitter sits in L0s, the block raises an exit request as soon as the port has something to send: a TLP with credits behind it, a DLLP, or a multicast DMA TLP. It also raises the exit request if the effective ASPM enable goes away. The exit request stays up until the physical layer reports the link back in L0. The qualification window is 7 µs. It is written as a cycle count derived from the clock frequency in MHz and the window length in ns.

The receive-side L0s handshake is outside this block; the receiver always follows the link partner's L0s entry and exit. Electrical idle signalling and physical-layer sequencing are also outside the block. Traffic between functions inside the port never reaches the link and has no input here. All pins are plain control and status levels. There is no data stream at the boundary, so no valid/ready handshake or back-pressure applies.

Top module: `tx_l0s_entry_ctrl`

## Requirements
- R1: After reset, `tx_l0s_enter_req`, `tx_l0s_exit_req` and `tx_in_l0s` are all 0.
- R2: The effective enable is the AND of all `func_l0s_en` bits. With any bit at 0, no entry request is ever made.
- R3: When all entry conditions are true at QUAL_CYCLES consecutive rising edges (QUAL_CYCLES = CLK_MHZ*QUAL_NS/1000), `tx_l0s_enter_req` is 1 right after the last of those edges, and not after the edge before it.
- R4: If any condition is false at one edge during qualification, the count restarts. A full QUAL_CYCLES run of true edges is then needed again.
- R5: With `port_is_up`=1, peer i passes when `peer_rx_l0s[i]`=1, or `peer_d3[i]`=1, or `peer_link_up[i]`=0. Entry requires every peer to pass.
- R6: With `port_is_up`=0, entry requires `usp_rx_l0s`=1, and the peer vectors have no effect.
- R7: A non-empty egress buffer (`egress_empty`=0) blocks entry only while `fc_credit_avail`=1.
- R8: While `dllp_pending`=1, no entry is made.
- R9: `mcast_dma_tlp`=1 counts as link traffic. It blocks entry, and in L0s it causes an exit.
- R10: In L0s, sendable traffic (R7 with credits, R8 or R9) makes `tx_l0s_exit_req` 1 after the next edge and `tx_in_l0s` 0. The exit request holds until `phy_in_l0`=1 is seen at an edge, and drops after that edge.
- R11: Clearing any `func_l0s_en` bit while in L0s makes `tx_l0s_exit_req` 1 after the next edge.
- R12: `tx_l0s_enter_req` is a single-cycle pulse, and it is never 1 in the same cycle as `tx_l0s_exit_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_l0s_en | input | NUM_FUNC | Per-function L0s ASPM enable |
| port_is_up | input | 1 | 1 = upstream-port mode, 0 = downstream-port mode |
| peer_rx_l0s | input | NUM_PEER | Receive lanes of each downstream peer are in L0s |
| peer_d3 | input | NUM_PEER | Downstream peer is in D3 |
| peer_link_up | input | NUM_PEER | Downstream peer link is up |
| usp_rx_l0s | input | 1 | Receive lanes of the partition's upstream port are in L0s |
| egress_empty | input | 1 | Egress TLP buffer is empty |
| fc_credit_avail | input | 1 | Credits exist to send the head TLP |
| dllp_pending | input | 1 | A DLLP awaits transmission |
| mcast_dma_tlp | input | 1 | A DMA TLP hit the multicast aperture |
| phy_in_l0 | input | 1 | Physical layer reports the link in L0 |
| tx_l0s_enter_req | output | 1 | One-cycle request to enter transmit L0s |
| tx_l0s_exit_req | output | 1 | Request to leave transmit L0s |
| tx_in_l0s | output | 1 | Transmit side is held in L0s |

## Verification
The assertions check on every cycle the pulse shape of the entry request and its exclusion with the exit request. They also check that an entry is only made after the enable was up, that any wake condition or lost enable in L0s is followed by an exit request one cycle later, and that the exit request holds until L0 is reported. The qualification counter is checked to stay in range and to finish only after a run of true cycles. Only the bench scenarios can show the exact entry cycle, the restart after a single broken cycle, the peer exclusion rules for D3 and link-down ports, the mode-dependent choice of peer status, and the credit qualification of a non-empty buffer.

// File: rtl/tx_l0s_pkg.sv
package tx_l0s_pkg;
  typedef enum logic [1:0] {
    ST_QUAL = 2'd0,
    ST_L0S  = 2'd1,
    ST_EXIT = 2'd2
  } tx_l0s_state_e;
endpackage

// File: rtl/tx_l0s_peer_qual.sv
// Decides whether the partition's peer ports allow transmit L0s entry.
module tx_l0s_peer_qual #(
  parameter int NUM_PEER = 8
) (
  input  logic                port_is_up,
  input  logic [NUM_PEER-1:0] peer_rx_l0s,
  input  logic [NUM_PEER-1:0] peer_d3,
  input  logic [NUM_PEER-1:0] peer_link_up,
  input  logic                usp_rx_l0s,
  output logic                peers_ok
);
  logic [NUM_PEER-1:0] pass_vec;

  // A peer is ignored when powered down or when its link is down.
  for (genvar gi = 0; gi < NUM_PEER; gi++) begin : g_peer
    assign pass_vec[gi] = peer_rx_l0s[gi] | peer_d3[gi] | ~peer_link_up[gi];
  end

  assign peers_ok = port_is_up ? (&pass_vec) : usp_rx_l0s;
endmodule

// File: rtl/tx_l0s_qual_timer.sv
// Counts consecutive cycles with run asserted; done on the last cycle of the window.
module tx_l0s_qual_timer #(
  parameter int QUAL_CYCLES = 1750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (done)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R3: count stays inside the window
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4: a broken cycle leaves the count at zero
  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // R3: completion needs run in the previous cycle too
  p_done_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run));
endmodule

// File: rtl/tx_l0s_entry_ctrl.sv
module tx_l0s_entry_ctrl
  import tx_l0s_pkg::*;
#(
  parameter int NUM_FUNC = 4,
  parameter int NUM_PEER = 8,
  parameter int CLK_MHZ  = 250,
  parameter int QUAL_NS  = 7000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FUNC-1:0] func_l0s_en,
  input  logic                port_is_up,
  input  logic [NUM_PEER-1:0] peer_rx_l0s,
  input  logic [NUM_PEER-1:0] peer_d3,
  input  logic [NUM_PEER-1:0] peer_link_up,
  input  logic                usp_rx_l0s,
  input  logic                egress_empty,
  input  logic                fc_credit_avail,
  input  logic                dllp_pending,
  input  logic                mcast_dma_tlp,
  input  logic                phy_in_l0,
  output logic                tx_l0s_enter_req,
  output logic                tx_l0s_exit_req,
  output logic                tx_in_l0s
);
  localparam int QUAL_CYCLES = (CLK_MHZ * QUAL_NS) / 1000;

  tx_l0s_state_e state_q, state_d;
  logic          enter_q;
  logic          aspm_en, peers_ok, link_busy, qual_run, qual_done, wake;

  // Effective enable: only settings common to every function apply.
  assign aspm_en = &func_l0s_en;

  // Link traffic: a TLP that could go out, a DLLP, or a multicast DMA TLP.
  assign link_busy = (!egress_empty && fc_credit_avail) || dllp_pending || mcast_dma_tlp;

  tx_l0s_peer_qual #(.NUM_PEER(NUM_PEER)) u_peer_qual (
    .port_is_up   (port_is_up),
    .peer_rx_l0s  (peer_rx_l0s),
    .peer_d3      (peer_d3),
    .peer_link_up (peer_link_up),
    .usp_rx_l0s   (usp_rx_l0s),
    .peers_ok     (peers_ok)
  );

  assign qual_run = (state_q == ST_QUAL) && aspm_en && peers_ok && !link_busy;

  tx_l0s_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (qual_run),
    .done  (qual_done)
  );

  assign wake = link_busy || !aspm_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_QUAL: if (qual_done) state_d = ST_L0S;
      ST_L0S:  if (wake)      state_d = ST_EXIT;
      ST_EXIT: if (phy_in_l0) state_d = ST_QUAL;
      default:                state_d = ST_QUAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_QUAL;
      enter_q <= 1'b0;
    end else begin
      state_q <= state_d;
      enter_q <= (state_q == ST_QUAL) && qual_done;
    end
  end

  assign tx_l0s_enter_req = enter_q;
  assign tx_l0s_exit_req  = (state_q == ST_EXIT);
  assign tx_in_l0s        = (state_q == ST_L0S);

  // R12: entry request lasts one cycle
  p_enter_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_l0s_enter_req |=> !tx_l0s_enter_req);

  // R12: entry and exit requests are exclusive
  p_req_mutex_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_l0s_enter_req && tx_l0s_exit_req));

  // R2: an entry only follows a cycle with the combined enable up
  p_enter_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_l0s_enter_req |-> $past(&func_l0s_en));

  // R10: traffic in L0s leads to an exit request next cycle
  p_wake_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_l0s && ((!egress_empty && fc_credit_avail) || dllp_pending || mcast_dma_tlp))
      |=> tx_l0s_exit_req);

  // R10: exit request holds until L0 is reported
  p_exit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_l0s_exit_req && !phy_in_l0) |=> tx_l0s_exit_req);

  // R11: losing the enable in L0s forces an exit
  p_disable_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_l0s && !(&func_l0s_en)) |=> tx_l0s_exit_req);
endmodule

// File: tb/tx_l0s_entry_ctrl_tb.sv
`timescale 1ns/1ps
module tx_l0s_entry_ctrl_tb;
  localparam int NF = 4;
  localparam int NP = 8;
  localparam int MHZ = 250;
  localparam int WNS = 40;
  localparam int Q = (MHZ * WNS) / 1000;  // 10 cycles

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NF-1:0] func_l0s_en;
  logic          port_is_up;
  logic [NP-1:0] peer_rx_l0s, peer_d3, peer_link_up;
  logic          usp_rx_l0s, egress_empty, fc_credit_avail, dllp_pending;
  logic          mcast_dma_tlp, phy_in_l0;
  logic          tx_l0s_enter_req, tx_l0s_exit_req, tx_in_l0s;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  tx_l0s_entry_ctrl #(.NUM_FUNC(NF), .NUM_PEER(NP), .CLK_MHZ(MHZ), .QUAL_NS(WNS)) u_dut (
    .clk(clk), .rst_n(rst_n), .func_l0s_en(func_l0s_en), .port_is_up(port_is_up),
    .peer_rx_l0s(peer_rx_l0s), .peer_d3(peer_d3), .peer_link_up(peer_link_up),
    .usp_rx_l0s(usp_rx_l0s), .egress_empty(egress_empty), .fc_credit_avail(fc_credit_avail),
    .dllp_pending(dllp_pending), .mcast_dma_tlp(mcast_dma_tlp), .phy_in_l0(phy_in_l0),
    .tx_l0s_enter_req(tx_l0s_enter_req), .tx_l0s_exit_req(tx_l0s_exit_req),
    .tx_in_l0s(tx_in_l0s)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // Reset with all conditions good except the enable.
  task automatic do_reset();
    rst_n = 1'b0;
    func_l0s_en = '0; port_is_up = 1'b1;
    peer_rx_l0s = '1; peer_d3 = '0; peer_link_up = '1; usp_rx_l0s = 1'b1;
    egress_empty = 1'b1; fc_credit_avail = 1'b1; dllp_pending = 1'b0;
    mcast_dma_tlp = 1'b0; phy_in_l0 = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Called at a negedge right after conditions became true.
  task automatic expect_entry(input string tag);
    cycles(Q - 1);
    check({tag, " early"}, tx_l0s_enter_req, 1'b0);
    cycles(1);
    check({tag, " on time"}, tx_l0s_enter_req, 1'b1);
    check({tag, " mutex R12"}, tx_l0s_exit_req, 1'b0);
    cycles(1);
    check({tag, " pulse R12"}, tx_l0s_enter_req, 1'b0);
    check({tag, " in_l0s"}, tx_in_l0s, 1'b1);
  endtask

  task automatic expect_none(input string tag);
    cycles(Q + 5);
    check(tag, tx_in_l0s, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 enter", tx_l0s_enter_req, 1'b0);
    check("R1 exit", tx_l0s_exit_req, 1'b0);
    check("R1 in_l0s", tx_in_l0s, 1'b0);
  endtask

  task automatic t_basic();
    do_reset();
    func_l0s_en = '1;
    expect_entry("R3 basic");
  endtask

  task automatic t_func_and();
    do_reset();
    func_l0s_en = 4'b1011;
    expect_none("R2 one function off");
    func_l0s_en = '1;
    expect_entry("R2 all functions on");
  endtask

  task automatic t_restart();
    do_reset();
    func_l0s_en = '1;
    cycles(Q - 3);
    dllp_pending = 1'b1;
    cycles(1);
    dllp_pending = 1'b0;
    expect_entry("R4 restart");
  endtask

  task automatic t_peers();
    do_reset();
    func_l0s_en = '1;
    peer_rx_l0s[2] = 1'b0; peer_d3[2] = 1'b1;
    peer_rx_l0s[5] = 1'b0; peer_link_up[5] = 1'b0;
    expect_entry("R5 excluded peers");
    do_reset();
    func_l0s_en = '1;
    peer_rx_l0s[4] = 1'b0;
    expect_none("R5 active peer not in L0s");
  endtask

  task automatic t_dsp_mode();
    do_reset();
    port_is_up = 1'b0; usp_rx_l0s = 1'b0; func_l0s_en = '1;
    expect_none("R6 upstream port busy");
    usp_rx_l0s = 1'b1; peer_rx_l0s = '0;
    expect_entry("R6 peers ignored");
  endtask

  task automatic t_credits();
    do_reset();
    func_l0s_en = '1; egress_empty = 1'b0; fc_credit_avail = 1'b1;
    expect_none("R7 TLP with credits");
    fc_credit_avail = 1'b0;
    expect_entry("R7 TLP without credits");
  endtask

  task automatic t_dllp();
    do_reset();
    func_l0s_en = '1; dllp_pending = 1'b1;
    expect_none("R8 dllp pending");
  endtask

  task automatic t_mcast();
    do_reset();
    func_l0s_en = '1; mcast_dma_tlp = 1'b1;
    expect_none("R9 mcast blocks");
    mcast_dma_tlp = 1'b0;
    expect_entry("R9 entry");
    mcast_dma_tlp = 1'b1;
    cycles(1);
    mcast_dma_tlp = 1'b0;
    check("R9 mcast wakes", tx_l0s_exit_req, 1'b1);
  endtask

  task automatic t_wake();
    do_reset();
    func_l0s_en = '1;
    expect_entry("R10 entry");
    cycles(3);
    check("R10 stays in L0s", tx_in_l0s, 1'b1);
    egress_empty = 1'b0;
    cycles(1);
    check("R10 exit req", tx_l0s_exit_req, 1'b1);
    check("R10 left L0s", tx_in_l0s, 1'b0);
    egress_empty = 1'b1;
    cycles(4);
    check("R10 exit held", tx_l0s_exit_req, 1'b1);
    phy_in_l0 = 1'b1;
    cycles(1);
    check("R10 exit dropped", tx_l0s_exit_req, 1'b0);
    check("R12 no enter after exit", tx_l0s_enter_req, 1'b0);
  endtask

  task automatic t_disable();
    do_reset();
    func_l0s_en = '1;
    expect_entry("R11 entry");
    func_l0s_en[0] = 1'b0;
    cycles(1);
    check("R11 forced exit", tx_l0s_exit_req, 1'b1);
    phy_in_l0 = 1'b1;
    expect_none("R11 no reentry while disabled");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_func_and();
    t_restart();
    t_peers();
    t_dsp_mode();
    t_credits();
    t_dllp();
    t_mcast();
    t_wake();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule